// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block links two parallel data buses, called side A and side B, through an inverting transceiver. Each side has its own capture register. A strobe input belongs to each direction. A rising strobe on the A-to-B strobe stores the A bus in the A-side register. A rising strobe on the B-to-A strobe stores the B bus in the B-side register. Both strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the block stores the bus value present in the cycle the edge is detected.

The outputs depend on three controls. An active-low enable and a direction input pick which bus is driven, if any. A per-direction source select picks what that bus carries: the live word from the opposite bus, or that direction's stored word. Whatever is driven is the bitwise complement of its source. Each bus is modelled as three separate vectors: input data, output data and output enable. There are no tri-state nets. Capture continues while both outputs are disabled, so a word can be stored in isolation and replayed later.

Top module: `reg_inv_xcvr`

## Requirements
- R1: A rising edge on `stb_ab` loads `a_in` into the A-side store. The new value is visible on `b_out` (replay path) no later than the fourth system clock edge after `stb_ab` rises, and `a_in` is held stable over that window.
- R2: A rising edge on `stb_ba` loads `b_in` into the B-side store, with the same timing as R1, and the stored value is visible on `a_out`.
- R3: When `en_n`=0 and `dir`=1, the B side is driven: `b_oe` is all ones and `a_oe` is all zeros.
- R4: When `en_n`=0 and `dir`=0, the A side is driven: `a_oe` is all ones and `b_oe` is all zeros.
- R5: When `en_n`=1, both output-enable vectors are all zeros and both output data vectors read zero.
- R6: While B is driven, `b_out` equals `~a_in` if `src_ab`=0 and equals the complement of the A-side store if `src_ab`=1.
- R7: While A is driven, `a_out` equals `~b_in` if `src_ba`=0 and equals the complement of the B-side store if `src_ba`=1.
- R8: Both stores capture on their strobe edges whatever the values of `en_n` and `dir`, including while both sides are disabled.
- R9: At no time are `a_oe` and `b_oe` both non-zero.
- R10: After synchronous reset (`rst_n`=0 on a clock edge), both stores hold zero and both output enables are zero.
- R11: Changes of `en_n`, `dir`, `src_ab` or `src_ba` reach the outputs in the same cycle, with no register delay.
- R12: Only a rising strobe edge captures. A strobe held high, or a falling strobe, leaves the store unchanged when the bus data changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_ab | input | 1 | Asynchronous strobe that stores the A bus |
| stb_ba | input | 1 | Asynchronous strobe that stores the B bus |
| src_ab | input | 1 | B-side source: 0 live A bus, 1 A-side store |
| src_ba | input | 1 | A-side source: 0 live B bus, 1 B-side store |
| dir | input | 1 | 1 drives side B, 0 drives side A |
| en_n | input | 1 | Active-low output enable |
| a_in | input | W | Data arriving on bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | W | Per-bit enable for bus A |
| b_in | input | W | Data arriving on bus B |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | W | Per-bit enable for bus B |

## Verification
The capture properties assume the bus word is stable across the synchroniser window, which spans from the strobe rising until the detected edge is stored. The stimulus tasks therefore set the data together with the strobe and hold both for four system clocks before either changes. The output properties assume nothing about the inputs, because enable, direction and select act combinationally. The stimulus walks all sixteen combinations of these four controls against a reference model kept in the bench.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered inverting transceiver.
package xcvr_pkg;
    // Which bus, if either, is currently driven.
    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } bus_drive_t;

    // Decode the enable and direction controls into a drive selection.
    function automatic bus_drive_t decode_drive(input logic en_n, input logic dir);
        bus_drive_t d;
        d.drive_a = ~en_n & ~dir;
        d.drive_b = ~en_n &  dir;
        return d;
    endfunction
endpackage

// File: rtl/xcvr_edge_sync.sv
// Module: xcvr_edge_sync
// Brings an asynchronous strobe into the clk domain through a chain of
// SYNC_STAGES flops and flags one cycle per detected rising edge.
// Assumes the strobe stays high and low long enough to be sampled.
module xcvr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the strobe through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], strobe};
    end

    // A rising edge shows as new-high, previous-low at the synchronised end.
    always_comb rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
endmodule

// File: rtl/xcvr_capture_reg.sv
// Module: xcvr_capture_reg
// Word-wide store loaded when the load flag is set; cleared by reset.
// Assumes the load flag is already in the clk domain.
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the last loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_drive_path.sv
// Module: xcvr_drive_path
// Output stage for one direction. It picks the live or stored word, inverts
// it and produces the data and per-bit enable. Purely combinational.
// Data reads zero while the path is disabled.
module xcvr_drive_path #(
    parameter int W = 8
) (
    input  logic         enable,
    input  logic         use_store,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] data,
    output logic [W-1:0] oe
);
    logic [W-1:0] source;

    // Select the source word and invert it while enabled.
    always_comb begin
        source = use_store ? stored : live;
        data   = enable ? ~source : '0;
        oe     = {W{enable}};
    end
endmodule

// File: rtl/reg_inv_xcvr.sv
// Module: reg_inv_xcvr (top)
// Registered inverting transceiver between buses A and B. Each direction has
// its own synchronised capture strobe and store. The enable, direction and
// select inputs act combinationally on the outputs. The strobes are
// asynchronous; the bus data must be stable while a strobe edge is in flight.
module reg_inv_xcvr
    import xcvr_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_ab,
    input  logic         stb_ba,
    input  logic         src_ab,
    input  logic         src_ba,
    input  logic         dir,
    input  logic         en_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    localparam int NDIR = 2;   // index 0: A to B, index 1: B to A

    logic       [NDIR-1:0] strobe_v, cap_v, sel_v, en_v;
    logic [NDIR-1:0][W-1:0] live_v, store_v, data_v, oe_v;
    bus_drive_t            drv;
    logic                  cap_a, cap_b;
    logic [W-1:0]          store_a, store_b;

    // Decode which side is driven from enable and direction.
    always_comb drv = decode_drive(en_n, dir);

    // Gather per-direction inputs: direction 0 feeds bus B, 1 feeds bus A.
    always_comb begin
        strobe_v = {stb_ba, stb_ab};
        sel_v    = {src_ba, src_ab};
        en_v     = {drv.drive_a, drv.drive_b};
        live_v   = {b_in, a_in};
    end

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            xcvr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .strobe(strobe_v[g]), .rise(cap_v[g])
            );
            xcvr_capture_reg #(.W(W)) u_store (
                .clk(clk), .rst_n(rst_n), .load(cap_v[g]),
                .d(live_v[g]), .q(store_v[g])
            );
            xcvr_drive_path #(.W(W)) u_path (
                .enable(en_v[g]), .use_store(sel_v[g]), .live(live_v[g]),
                .stored(store_v[g]), .data(data_v[g]), .oe(oe_v[g])
            );
        end
    endgenerate

    // Route the path outputs to the bus ports and name the stores.
    always_comb begin
        b_out   = data_v[0];
        b_oe    = oe_v[0];
        a_out   = data_v[1];
        a_oe    = oe_v[1];
        cap_a   = cap_v[0];
        cap_b   = cap_v[1];
        store_a = store_v[0];
        store_b = store_v[1];
    end
endmodule

// File: rtl/xcvr_checker.sv
// Module: xcvr_checker
// Properties for reg_inv_xcvr, attached by the bind below.
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_ab,
    input logic         src_ba,
    input logic         dir,
    input logic         en_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input logic         cap_a,
    input logic         cap_b,
    input logic [W-1:0] store_a,
    input logic [W-1:0] store_b
);
    assert_one_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    assert_b_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|b_oe) |-> (!en_n && dir && (&b_oe)));

    assert_a_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|a_oe) |-> (!en_n && !dir && (&a_oe)));

    assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    assert_b_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|b_oe) |-> (b_out == ~(src_ab ? store_a : a_in)));

    assert_a_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|a_oe) |-> (a_out == ~(src_ba ? store_b : b_in)));

    assert_cap_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (store_a == $past(a_in)));

    assert_cap_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_b |=> (store_b == $past(b_in)));

    assert_hold_a_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_a |=> $stable(store_a));

    assert_hold_b_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_b |=> $stable(store_b));
endmodule

bind reg_inv_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
    .clk(clk), .rst_n(rst_n), .src_ab(src_ab), .src_ba(src_ba), .dir(dir),
    .en_n(en_n), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe), .cap_a(cap_a), .cap_b(cap_b),
    .store_a(store_a), .store_b(store_b)
);

// File: tb/test_reg_inv_xcvr.sv
// Directed bench for reg_inv_xcvr; one task per scenario.
module test_reg_inv_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stb_ab = 1'b0, stb_ba = 1'b0;
    logic         src_ab = 1'b0, src_ba = 1'b0, dir = 1'b0, en_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] m_store_a = '0, m_store_b = '0;

    always #4 clk = ~clk;

    reg_inv_xcvr #(.W(W)) i_reg_inv_xcvr (
        .clk(clk), .rst_n(rst_n), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .src_ab(src_ab), .src_ba(src_ba), .dir(dir), .en_n(en_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic e, input logic d, input logic sab, input logic sba);
        en_n = e; dir = d; src_ab = sab; src_ba = sba;
        #1;
    endtask

    // Compare all four outputs against the reference model.
    task automatic check_model(input string req);
        logic da, db;
        da = !en_n && !dir;
        db = !en_n && dir;
        check({req, " a_oe"}, a_oe, {W{da}});
        check({req, " b_oe"}, b_oe, {W{db}});
        check({req, " a_out"}, a_out, da ? ~(src_ba ? m_store_b : b_in) : '0);
        check({req, " b_out"}, b_out, db ? ~(src_ab ? m_store_a : a_in) : '0);
    endtask

    task automatic cap_a(input logic [W-1:0] v);
        @(negedge clk); a_in = v; stb_ab = 1'b1;
        repeat (4) @(negedge clk);
        stb_ab = 1'b0; m_store_a = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic cap_b(input logic [W-1:0] v);
        @(negedge clk); b_in = v; stb_ba = 1'b1;
        repeat (4) @(negedge clk);
        stb_ba = 1'b0; m_store_b = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;  // R10
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 a_oe", a_oe, '0);
        check("R10 b_oe", b_oe, '0);
        a_in = 8'h5A; b_in = 8'h3C;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        check("R10 store_a replay", b_out, 8'hFF);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        check("R10 store_b replay", a_out, 8'hFF);
    endtask

    task automatic t_isolated_capture;  // R1 R2 R8
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        cap_a(8'hA5);
        cap_b(8'h0F);
        a_in = 8'h11; b_in = 8'h22;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 R8 replay A store", b_out, ~8'hA5);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 R8 replay B store", a_out, ~8'h0F);
    endtask

    task automatic t_driven_capture;  // R1 R2 R8 with outputs active
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        cap_a(8'h81);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        cap_b(8'h7E);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 capture while A driven", b_out, ~8'h81);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 capture while B driven", a_out, ~8'h7E);
    endtask

    task automatic t_all_combos;  // R3 R4 R5 R6 R7 R9 R11
        a_in = 8'hC3; b_in = 8'h96;
        for (int i = 0; i < 16; i++) begin
            set_ctl(i[3], i[2], i[1], i[0]);
            check_model($sformatf("R3 R4 R5 R6 R7 combo%0d", i));
            check("R9 one bus", {7'd0, (|a_oe) && (|b_oe)}, '0);
        end
        @(posedge clk); #1;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R11 same-cycle live", b_out, ~8'hC3);
        src_ab = 1'b1; #1;
        check("R11 same-cycle select", b_out, ~m_store_a);
        dir = 1'b0; #1;
        check("R11 same-cycle dir", b_oe, '0);
    endtask

    task automatic t_edge_only;  // R12
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        cap_a(8'h44);
        @(negedge clk); stb_ab = 1'b1; a_in = 8'h44;
        repeat (5) @(negedge clk);
        a_in = 8'hEE;                   // change while strobe stays high
        repeat (5) @(negedge clk);
        stb_ab = 1'b0;                  // falling edge
        repeat (5) @(negedge clk);
        a_in = 8'h01;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R12 held/falling no capture", b_out, ~8'h44);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 live after replay", b_out, ~8'h01);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_isolated_capture();
        t_driven_capture();
        t_all_combos();
        t_edge_only();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule